// File: doc/BRIEF.md
# Vector Element Insert Extract Unit

This unit is the datapath bridge between a 32-bit scalar value and a 128-bit vector value. Each request names an operation, an element size (byte, halfword or word) and a lane number. It can pull one element out of a source vector into a scalar result, either sign-extended or zero-extended. It can also write a scalar into one lane of a destination vector or replicate a scalar across every lane.

The surrounding pipeline supplies three values: the scalar operand, the source vector to read from, and the current contents of the destination vector for a lane write. The unit sends back either a scalar result or a whole new vector. Both results are registered and appear one clock after the request. A separate valid pulse marks each result. A request whose element size is reserved, or whose lane number does not exist at that size, raises an error pulse and leaves both results untouched.

Lanes are numbered from the least significant end. Lane n of size w bits occupies vector bits [n*w + w-1 : n*w].

Top module: `vx_bridge`

## Requirements
- R1: While reset is asserted and immediately after it is released, `scalar_valid`, `vector_valid` and `err` are 0, and `scalar_out` and `vector_out` are all zeros.
- R2: Operation code 0 (signed extract) with size code 0 (byte) or 1 (halfword) returns the selected element in `scalar_out`, sign-extended to 32 bits.
- R3: Operation code 1 (unsigned extract) with a byte or halfword size returns the selected element zero-extended. Bits above 7 (byte) or above 15 (halfword) are 0.
- R4: With size code 2 (word), both extract operations return the selected 32-bit element unchanged.
- R5: Operation code 2 (insert) returns `dst_vec` with only the addressed lane replaced by the low 8, 16 or 32 bits of `scalar_in`. Every other lane keeps its value from `dst_vec`.
- R6: Operation code 3 (fill) returns a vector in which every lane holds the low 8, 16 or 32 bits of `scalar_in`.
- R7: A request with size code 3, or with a lane number of at least 16, 8 or 4 for byte, halfword or word, pulses `err` for one cycle. It raises neither valid flag and leaves `scalar_out` and `vector_out` unchanged.
- R8: A legal extract raises only `scalar_valid`. A legal insert or fill raises only `vector_valid`. The result register of the other kind keeps its value.
- R9: A result and its valid flag appear on the first clock edge after the cycle in which `in_valid` was high. With `in_valid` low, all three flags are 0 on the next cycle and both result registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 2 | Operation: 0 signed extract, 1 unsigned extract, 2 insert, 3 fill |
| fmt | input | 2 | Element size: 0 byte, 1 halfword, 2 word, 3 reserved |
| lane | input | 4 | Lane number |
| scalar_in | input | 32 | Scalar operand for insert and fill |
| src_vec | input | 128 | Vector read by the extract operations |
| dst_vec | input | 128 | Present destination contents used by insert |
| scalar_out | output | 32 | Registered scalar result |
| scalar_valid | output | 1 | Pulses with a new scalar result |
| vector_out | output | 128 | Registered vector result |
| vector_valid | output | 1 | Pulses with a new vector result |
| err | output | 1 | Pulses for an illegal size or lane |

## Verification
Some lane numbers are legal at one element size and illegal at another. Examples are lane 8 at halfword size and lane 4 at word size. These cases are the hardest to reach, because the request must still leave both result registers exactly as they were. The stimulus therefore draws the lane number from the full 4-bit range at every size, with the reserved size mixed in. It also aims directed requests at the first illegal lane and the last legal lane of each size, so that an off-by-one bound shows up as a changed result or a missing error pulse. Insert requests use random `dst_vec` values and compare against a bench model, so a wrongly spread write lane is detected.

// File: rtl/vx_pkg.sv
`timescale 1ns/1ps
package vx_pkg;
  typedef enum logic [1:0] {
    OP_COPY_S = 2'd0,
    OP_COPY_U = 2'd1,
    OP_INSERT = 2'd2,
    OP_FILL   = 2'd3
  } vx_op_e;

  typedef enum logic [1:0] {
    FMT_BYTE = 2'd0,
    FMT_HALF = 2'd1,
    FMT_WORD = 2'd2,
    FMT_RSVD = 2'd3
  } vx_fmt_e;
endpackage

// File: rtl/vx_lane_check.sv
`timescale 1ns/1ps
module vx_lane_check #(
  parameter int VEC_W = 128,
  parameter int SCL_W = 32,
  parameter int IDX_W = 4
) (
  input  vx_pkg::vx_fmt_e   fmt,
  input  logic [IDX_W-1:0]  lane,
  output logic              ok
);
  localparam int N_BYTE = VEC_W / 8;
  localparam int N_HALF = VEC_W / 16;
  localparam int N_WORD = VEC_W / SCL_W;

  logic [31:0] lane_x;
  assign lane_x = 32'(lane);

  always_comb begin
    unique case (fmt)
      vx_pkg::FMT_BYTE: ok = (lane_x < N_BYTE);
      vx_pkg::FMT_HALF: ok = (lane_x < N_HALF);
      vx_pkg::FMT_WORD: ok = (lane_x < N_WORD);
      default:          ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/vx_extract.sv
`timescale 1ns/1ps
module vx_extract #(
  parameter int VEC_W = 128,
  parameter int SCL_W = 32,
  parameter int IDX_W = 4
) (
  input  logic [VEC_W-1:0]  vec,
  input  vx_pkg::vx_fmt_e   fmt,
  input  logic [IDX_W-1:0]  lane,
  input  logic              sign_ext,
  output logic [SCL_W-1:0]  res
);
  localparam int OFF_W = $clog2(VEC_W);

  logic [OFF_W-1:0] off_b, off_h, off_w;
  logic [7:0]       sel_b;
  logic [15:0]      sel_h;
  logic [SCL_W-1:0] sel_w;

  assign off_b = OFF_W'({lane, 3'b000});
  assign off_h = OFF_W'({lane, 4'b0000});
  assign off_w = OFF_W'(32'(lane) * SCL_W);

  assign sel_b = vec[off_b +: 8];
  assign sel_h = vec[off_h +: 16];
  assign sel_w = vec[off_w +: SCL_W];

  always_comb begin
    unique case (fmt)
      vx_pkg::FMT_BYTE: res = sign_ext ? {{(SCL_W-8){sel_b[7]}}, sel_b}
                                       : {{(SCL_W-8){1'b0}}, sel_b};
      vx_pkg::FMT_HALF: res = sign_ext ? {{(SCL_W-16){sel_h[15]}}, sel_h}
                                       : {{(SCL_W-16){1'b0}}, sel_h};
      vx_pkg::FMT_WORD: res = sel_w;
      default:          res = '0;
    endcase
  end
endmodule

// File: rtl/vx_merge.sv
`timescale 1ns/1ps
module vx_merge #(
  parameter int VEC_W = 128,
  parameter int SCL_W = 32,
  parameter int IDX_W = 4
) (
  input  logic [VEC_W-1:0]  old_vec,
  input  logic [SCL_W-1:0]  scalar,
  input  vx_pkg::vx_fmt_e   fmt,
  input  logic [IDX_W-1:0]  lane,
  input  logic              fill,
  output logic [VEC_W-1:0]  new_vec
);
  localparam int NB  = VEC_W / 8;
  localparam int BPW = SCL_W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic       hit;
    logic [7:0] src;

    always_comb begin
      unique case (fmt)
        vx_pkg::FMT_BYTE: begin
          hit = fill || (lane == IDX_W'(b));
          src = scalar[7:0];
        end
        vx_pkg::FMT_HALF: begin
          hit = fill || (lane == IDX_W'(b / 2));
          src = scalar[8*(b % 2) +: 8];
        end
        vx_pkg::FMT_WORD: begin
          hit = fill || (lane == IDX_W'(b / BPW));
          src = scalar[8*(b % BPW) +: 8];
        end
        default: begin
          hit = 1'b0;
          src = 8'h00;
        end
      endcase
    end

    assign new_vec[8*b +: 8] = hit ? src : old_vec[8*b +: 8];
  end
endmodule

// File: rtl/vx_bridge.sv
`timescale 1ns/1ps
module vx_bridge #(
  parameter int VEC_W = 128,
  parameter int SCL_W = 32,
  parameter int IDX_W = $clog2(VEC_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [1:0]        fmt,
  input  logic [IDX_W-1:0]  lane,
  input  logic [SCL_W-1:0]  scalar_in,
  input  logic [VEC_W-1:0]  src_vec,
  input  logic [VEC_W-1:0]  dst_vec,
  output logic [SCL_W-1:0]  scalar_out,
  output logic              scalar_valid,
  output logic [VEC_W-1:0]  vector_out,
  output logic              vector_valid,
  output logic              err
);
  import vx_pkg::*;

  vx_op_e  op_e;
  vx_fmt_e fmt_e;
  assign op_e  = vx_op_e'(op);
  assign fmt_e = vx_fmt_e'(fmt);

  logic             lane_ok;
  logic [SCL_W-1:0] ext_res;
  logic [VEC_W-1:0] mrg_res;

  vx_lane_check #(.VEC_W(VEC_W), .SCL_W(SCL_W), .IDX_W(IDX_W)) u_check (
    .fmt (fmt_e),
    .lane(lane),
    .ok  (lane_ok)
  );

  vx_extract #(.VEC_W(VEC_W), .SCL_W(SCL_W), .IDX_W(IDX_W)) u_extract (
    .vec     (src_vec),
    .fmt     (fmt_e),
    .lane    (lane),
    .sign_ext(op_e == OP_COPY_S),
    .res     (ext_res)
  );

  vx_merge #(.VEC_W(VEC_W), .SCL_W(SCL_W), .IDX_W(IDX_W)) u_merge (
    .old_vec(dst_vec),
    .scalar (scalar_in),
    .fmt    (fmt_e),
    .lane   (lane),
    .fill   (op_e == OP_FILL),
    .new_vec(mrg_res)
  );

  // next-state
  logic s_en, v_en, e_nx;
  logic is_copy;
  always_comb begin
    is_copy = (op_e == OP_COPY_S) || (op_e == OP_COPY_U);
    s_en    = in_valid && lane_ok && is_copy;
    v_en    = in_valid && lane_ok && !is_copy;
    e_nx    = in_valid && !lane_ok;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scalar_out   <= '0;
      vector_out   <= '0;
      scalar_valid <= 1'b0;
      vector_valid <= 1'b0;
      err          <= 1'b0;
    end else begin
      scalar_valid <= s_en;
      vector_valid <= v_en;
      err          <= e_nx;
      if (s_en) scalar_out <= ext_res;
      if (v_en) vector_out <= mrg_res;
    end
  end
endmodule

// File: rtl/vx_bridge_chk.sv
`timescale 1ns/1ps
module vx_bridge_chk #(
  parameter int VEC_W = 128,
  parameter int SCL_W = 32,
  parameter int IDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        op,
  input logic [1:0]        fmt,
  input logic [IDX_W-1:0]  lane,
  input logic [SCL_W-1:0]  scalar_in,
  input logic [VEC_W-1:0]  src_vec,
  input logic [VEC_W-1:0]  dst_vec,
  input logic [SCL_W-1:0]  scalar_out,
  input logic              scalar_valid,
  input logic [VEC_W-1:0]  vector_out,
  input logic              vector_valid,
  input logic              err
);
  localparam int NB = VEC_W / 8;

  AST_ONE_RESULT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(scalar_valid && vector_valid)); // R8

  AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!scalar_valid && !vector_valid)); // R7

  AST_SCALAR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (scalar_valid || vector_valid || err) |-> $past(in_valid)); // R9

  AST_SCALAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !scalar_valid |-> $stable(scalar_out)); // R9

  AST_VECTOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vector_valid |-> $stable(vector_out)); // R9

  AST_ZERO_EXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (scalar_valid && $past(op == 2'd1 && fmt == 2'd0)) |-> (scalar_out[SCL_W-1:8] == '0)); // R3

  AST_FILL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (vector_valid && $past(op == 2'd3 && fmt == 2'd0))
      |-> (vector_out == {NB{$past(scalar_in[7:0])}})); // R6
endmodule

bind vx_bridge vx_bridge_chk #(.VEC_W(VEC_W), .SCL_W(SCL_W), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/vx_bridge_tb_top.sv
`timescale 1ns/1ps
module vx_bridge_tb_top;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   op;
  logic [1:0]   fmt;
  logic [3:0]   lane;
  logic [31:0]  scalar_in;
  logic [127:0] src_vec;
  logic [127:0] dst_vec;
  logic [31:0]  scalar_out;
  logic         scalar_valid;
  logic [127:0] vector_out;
  logic         vector_valid;
  logic         err;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [31:0]  exp_s;
  logic [127:0] exp_v;

  vx_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .fmt(fmt),
    .lane(lane), .scalar_in(scalar_in), .src_vec(src_vec), .dst_vec(dst_vec),
    .scalar_out(scalar_out), .scalar_valid(scalar_valid),
    .vector_out(vector_out), .vector_valid(vector_valid), .err(err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int elem_w(input logic [1:0] f);
    return (f == 2'd0) ? 8 : (f == 2'd1) ? 16 : 32;
  endfunction

  function automatic bit legal(input logic [1:0] f, input logic [3:0] n);
    if (f == 2'd3) return 0;
    return int'(n) < (128 / elem_w(f));
  endfunction

  function automatic logic [31:0] ref_extract(input logic [127:0] v, input logic [1:0] f,
                                              input logic [3:0] n, input bit sgn);
    logic [31:0] e;
    int w;
    w = elem_w(f);
    e = '0;
    for (int k = 0; k < w; k++) e[k] = v[int'(n) * w + k];
    if (sgn) for (int k = w; k < 32; k++) e[k] = e[w-1];
    return e;
  endfunction

  function automatic logic [127:0] ref_insert(input logic [127:0] old, input logic [31:0] s,
                                              input logic [1:0] f, input logic [3:0] n);
    logic [127:0] r;
    int w;
    w = elem_w(f);
    r = old;
    for (int k = 0; k < w; k++) r[int'(n) * w + k] = s[k];
    return r;
  endfunction

  function automatic logic [127:0] ref_fill(input logic [31:0] s, input logic [1:0] f);
    logic [127:0] r;
    int w;
    w = elem_w(f);
    for (int l = 0; l < 128 / w; l++)
      for (int k = 0; k < w; k++) r[l * w + k] = s[k];
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [1:0] f, input logic [3:0] n,
                     input logic [31:0] s, input logic [127:0] sv, input logic [127:0] dv);
    bit    lg;
    bit    esv, evv;
    string tag;
    @(negedge clk);
    in_valid = 1'b1; op = o; fmt = f; lane = n;
    scalar_in = s; src_vec = sv; dst_vec = dv;
    @(negedge clk);
    in_valid = 1'b0;
    lg  = legal(f, n);
    esv = lg && (o < 2'd2);
    evv = lg && (o >= 2'd2);
    if (!lg)             tag = "R7";
    else if (o == 2'd0)  tag = (f == 2'd2) ? "R4" : "R2";
    else if (o == 2'd1)  tag = (f == 2'd2) ? "R4" : "R3";
    else if (o == 2'd2)  tag = "R5";
    else                 tag = "R6";
    if (esv) exp_s = ref_extract(sv, f, n, o == 2'd0);
    if (evv) exp_v = (o == 2'd2) ? ref_insert(dv, s, f, n) : ref_fill(s, f);
    check(scalar_out == exp_s, tag, 128'(scalar_out), 128'(exp_s));
    check(vector_out == exp_v, tag, vector_out, exp_v);
    check({scalar_valid, vector_valid} == {esv, evv}, "R8",
          128'({scalar_valid, vector_valid}), 128'({esv, evv}));
    check(err == !lg, "R7", 128'(err), 128'(!lg));
  endtask

  task automatic idle_check();
    @(negedge clk);
    in_valid = 1'b0; op = 2'd3; fmt = 2'd0; scalar_in = $urandom;
    @(negedge clk);
    check({scalar_valid, vector_valid, err} == 3'b000, "R9",
          128'({scalar_valid, vector_valid, err}), 128'(0));
    check(scalar_out == exp_s && vector_out == exp_v, "R9",
          128'(scalar_out), 128'(exp_s));
  endtask

  function automatic logic [127:0] rvec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [1:0] ro, rf;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; in_valid = 1'b0; op = '0; fmt = '0; lane = '0;
    scalar_in = '0; src_vec = '0; dst_vec = '0;
    exp_s = '0; exp_v = '0;
    repeat (3) @(negedge clk);
    check({scalar_valid, vector_valid, err} == 3'b000 && scalar_out == '0 && vector_out == '0,
          "R1", 128'(scalar_out), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check({scalar_valid, vector_valid, err} == 3'b000 && vector_out == '0, "R1",
          vector_out, 128'(0));

    // directed corners
    run(2'd0, 2'd0, 4'd15, 32'h0, {8'h80, 120'h0}, '0);                 // R2 top byte negative
    run(2'd1, 2'd0, 4'd15, 32'h0, {8'h80, 120'h0}, '0);                 // R3
    run(2'd0, 2'd1, 4'd7,  32'h0, {16'h8001, 112'h0}, '0);              // R2 half
    run(2'd1, 2'd1, 4'd7,  32'h0, {16'h8001, 112'h0}, '0);              // R3 half
    run(2'd0, 2'd2, 4'd3,  32'h0, {32'hDEAD_BEEF, 96'h0}, '0);          // R4
    run(2'd1, 2'd2, 4'd0,  32'h0, {96'h0, 32'h8000_0001}, '0);          // R4
    run(2'd2, 2'd0, 4'd15, 32'h1234_56AB, '0, {128{1'b1}});             // R5
    run(2'd2, 2'd2, 4'd3,  32'hCAFE_F00D, '0, rvec());                  // R5
    run(2'd3, 2'd1, 4'd0,  32'hFFFF_A55A, '0, rvec());                  // R6
    run(2'd3, 2'd2, 4'd9,  32'h0BAD_CAFE, '0, rvec());                  // R7 fill lane out of range
    run(2'd0, 2'd1, 4'd8,  32'h0, rvec(), '0);                          // R7 half lane 8
    run(2'd2, 2'd2, 4'd4,  32'h1, '0, rvec());                          // R7 word lane 4
    run(2'd1, 2'd3, 4'd0,  32'h1, rvec(), rvec());                      // R7 reserved size
    idle_check();                                                        // R9

    // random stimulus
    for (int t = 0; t < 400; t++) begin
      ro = 2'($urandom_range(0, 3));
      rf = ($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      run(ro, rf, 4'($urandom_range(0, 15)), $urandom, rvec(), rvec());
      if ($urandom_range(0, 7) == 0) idle_check();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule